// File: doc/BRIEF.md
# MDIO management frame shifter

This block holds one 32-bit management word that is also the shift register for an MDIO management frame. Software writes a complete frame word (start, opcode, PHY address, register address, turnaround and 16 data bits) into the frame register. The write starts a transfer. The block then produces MDC from the system clock and sends the word out MSB first on MDIO. On every MDC period it also captures the line into the LSB. After 32 periods the word has rotated all the way round. For a write frame it reads back unchanged. For a read frame it reads back with the turnaround and data bits replaced by what came in from the line.

No preamble is generated. Software chooses clause 22 or clause 45 framing by the start and opcode values it writes. The block only looks at opcode bit 29 to decide when to release the line. A done status bit and a one-cycle interrupt mark completion. The frame register can be read at any time, including mid-transfer, when it returns the partly rotated word.

Top module: `mdio_frame_shifter`

## Requirements
- R1: After reset, MDC, MDIO output enable, MDIO output and the interrupt are low. The status register reads 0. The divider select reads 3. The frame register reads 0.
- R2: A host write to address 0 while idle loads the frame word and starts a transfer. From the next cycle status bit 0 (busy) is 1 and status bit 2 (done) is 0.
- R3: MDC is the system clock divided by 8, 16, 32 or 64 for divider select 0, 1, 2 or 3 (address 2, bits [1:0]). Each MDC period is low for its first half and high for its second half. A transfer takes exactly 32 periods, so the default setting takes 2048 system clocks. MDC stays low while idle.
- R4: The MDIO output shows frame bit 31 first and then one bit per period, changing only while MDC is low. The line is sampled on the MDC rise into bit 0 as the word rotates left by one.
- R5: A host read of address 0 during a transfer returns the word rotated left by the number of MDC rises so far, with the sampled line values in the low positions.
- R6: For a frame with bit 29 at 0, the output enable is high for all 32 periods, and the word reads back equal to what was written. The output enable is low whenever no transfer runs.
- R7: For a frame with bit 29 at 1, the output enable drops at the start of period 14 (frame bit 17) and stays low to the end. Bits 17..0 of the final word hold the sampled line values.
- R8: A start field of 00 (clause 45) is sent and sampled exactly like 01 (clause 22). Write and read behaviour follow bit 29 alone.
- R9: In the clock where the 32nd period ends, busy clears, done sets and the interrupt is high. The interrupt lasts exactly one cycle.
- R10: Host writes to any address are ignored while a transfer runs. Neither the frame word nor the divider select changes.
- R11: A host read strobe returns data on host_rdata in the next cycle. Address 1 gives the status word (busy bit 0, done bit 2). Address 2 gives the divider select. Address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 frame, 1 status, 2 divider select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after host_rd |
| irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, low releases the line |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
A wrong period count or a wrong divider compare shows at the ports at once. MDC or the output bit then moves on the wrong system clock, and the per-clock reference model flags it in that cycle. A wrong output-enable decision shows within one MDC period of turnaround, and a wrong capture or rotation shows as a mismatch in the read-back word at the end of the frame or in a mid-transfer read. Busy and done errors show in the interrupt timing and in status reads taken during and after a transfer.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_W   = 32;
  localparam int TA_IDX    = 14;   // period that carries frame bit 17
  localparam int OP_RD_BIT = 29;   // opcode bit marking a read
  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 2;
  localparam logic [1:0] DIVSEL_RESET = 2'd3;

  typedef enum logic [1:0] {
    HREG_FRAME  = 2'd0,
    HREG_STATUS = 2'd1,
    HREG_DIVSEL = 2'd2,
    HREG_NONE   = 2'd3
  } hreg_e;
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_direct
      assign dout = din;
    end else begin : g_sync
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
      assign dout = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int BASE_DIV = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W:0]   full_w;
  logic [CNT_W-1:0] cnt, cnt_last, half_last;

  assign full_w    = (CNT_W+1)'(BASE_DIV) << div_sel;
  assign cnt_last  = CNT_W'(full_w - 1'b1);
  assign half_last = CNT_W'((full_w >> 1) - 1'b1);

  assign rise_tick = run && (cnt == half_last);
  assign fall_tick = run && (cnt == cnt_last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)      mdc <= 1'b1;
      else if (fall_tick) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               line_in,
  output logic [FRAME_W-1:0] shreg,
  output logic               busy,
  output logic               done,
  output logic               done_pulse,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W:0]   TA_POS   = (IDX_W+1)'(TA_IDX);

  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   next_idx;
  logic             rd_frame;

  assign next_idx = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      done_pulse <= 1'b0;
      mdio_o     <= 1'b0;
      mdio_oe    <= 1'b0;
      idx        <= '0;
      rd_frame   <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (start) begin
        shreg    <= load_val;
        busy     <= 1'b1;
        done     <= 1'b0;
        idx      <= '0;
        rd_frame <= load_val[OP_RD_BIT];
        mdio_o   <= load_val[FRAME_W-1];
        mdio_oe  <= 1'b1;
      end else if (busy) begin
        if (rise_tick)
          shreg <= {shreg[FRAME_W-2:0], line_in};
        if (fall_tick) begin
          if (idx == LAST_IDX) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            done_pulse <= 1'b1;
            mdio_o     <= 1'b0;
            mdio_oe    <= 1'b0;
          end else begin
            idx     <= next_idx[IDX_W-1:0];
            mdio_o  <= shreg[FRAME_W-1];
            mdio_oe <= !(rd_frame && (next_idx >= TA_POS));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int BASE_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SEL_W = 2;

  hreg_e            addr_e;
  logic [SEL_W-1:0] div_sel;
  logic             busy, done, start, line_in, rise_tick, fall_tick;
  logic [31:0]      shreg, status_w;

  assign addr_e = hreg_e'(host_addr);
  assign start  = host_wr && !busy && (addr_e == HREG_FRAME);

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(mdio_i), .dout(line_in)
  );

  mdc_divider #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div_sel(div_sel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .load_val(host_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .line_in(line_in),
    .shreg(shreg), .busy(busy), .done(done), .done_pulse(irq),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst)
      div_sel <= DIVSEL_RESET;
    else if (host_wr && !busy && addr_e == HREG_DIVSEL)
      div_sel <= host_wdata[SEL_W-1:0];
  end

  always_comb begin
    status_w          = '0;
    status_w[ST_BUSY] = busy;
    status_w[ST_DONE] = done;
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_rd) begin
      unique case (addr_e)
        HREG_FRAME:  host_rdata <= shreg;
        HREG_STATUS: host_rdata <= status_w;
        HREG_DIVSEL: host_rdata <= {{(32-SEL_W){1'b0}}, div_sel};
        default:     host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_shifter_chk.sv
module mdio_frame_shifter_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic irq,
  input logic busy,
  input logic done
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R3
  AST_OUT_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R6
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done); // R2
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done && !busy && $past(busy))); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9
endmodule

bind mdio_frame_shifter mdio_frame_shifter_chk chk_i (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .irq(irq), .busy(busy), .done(done)
);

// File: tb/mdio_frame_shifter_tb_top.sv
module mdio_frame_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 1'b0, phy_o = 1'b0;
  logic [15:0] phy_data = '0;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_irq = 0;
  int          m_j = 0, m_div = 64, m_sel = 3;
  logic [31:0] m_frame = '0;
  int          phy_p = 0;

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_frame_shifter dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // reference model, advanced on each rising clock
  always @(posedge clk) begin
    m_irq = 0;
    if (rst) begin
      m_busy = 0; m_done = 0; m_j = 0; m_sel = 3; m_div = 64; m_frame = '0;
    end else if (m_busy) begin
      m_j = m_j + 1;
      if (m_j == 32 * m_div) begin
        m_busy = 0; m_done = 1; m_irq = 1;
      end
    end else if (host_wr) begin
      if (host_addr == 2'd0) begin
        m_busy = 1; m_j = 0; m_frame = host_wdata; m_done = 0;
        phy_p = 0; phy_oe = 1'b0;
      end else if (host_addr == 2'd2) begin
        m_sel = int'(host_wdata[1:0]); m_div = 8 << m_sel;
      end
    end
  end

  // behavioural PHY: answers read frames, changes on MDC falls
  always @(negedge mdc) begin
    phy_p = phy_p + 1;
    if (m_frame[29] && phy_p == 15) begin
      phy_oe = 1'b1; phy_o = 1'b0;
    end else if (m_frame[29] && phy_p >= 16 && phy_p <= 31) begin
      phy_o = phy_data[31 - phy_p];
    end else begin
      phy_oe = 1'b0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      logic e_mdc, e_o, e_oe;
      int p;
      p     = m_j / m_div;
      e_mdc = m_busy && ((m_j % m_div) >= m_div / 2);
      e_o   = m_busy ? m_frame[31 - p] : 1'b0;
      e_oe  = m_busy && !(m_frame[29] && p >= 14);
      checks++;
      if (mdc !== e_mdc) begin
        errors++; $display("FAIL R3 mdc act=%b exp=%b t=%0t", mdc, e_mdc, $time);
      end
      if (mdio_o !== e_o) begin
        errors++; $display("FAIL R4 mdio_o act=%b exp=%b t=%0t", mdio_o, e_o, $time);
      end
      if (mdio_oe !== e_oe) begin
        errors++;
        $display("FAIL %s mdio_oe act=%b exp=%b t=%0t",
                 m_frame[29] ? "R7" : "R6", mdio_oe, e_oe, $time);
      end
      if (irq !== m_irq) begin
        errors++; $display("FAIL R9 irq act=%b exp=%b t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    if (n % 32 == 0) return v;
    return (v << (n % 32)) | (v >> (32 - n % 32));
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd, f;
    int jj, rises;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R11 register map
    host_read(2'd1, rd); check_word("R1 status after reset", rd, 32'h0);
    host_read(2'd2, rd); check_word("R1 R11 divsel after reset", rd, 32'd3);
    host_read(2'd0, rd); check_word("R1 frame after reset", rd, 32'h0);
    host_read(2'd3, rd); check_word("R11 unused address", rd, 32'h0);

    // R3 default divider, R6 clause 22 write frame
    f = {2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA5C3};
    host_write(2'd0, f);
    host_read(2'd1, rd); check_word("R2 busy after start", rd, 32'h1);
    wait_idle();
    host_read(2'd0, rd); check_word("R6 write frame readback", rd, f);
    host_read(2'd1, rd); check_word("R9 done after frame", rd, 32'h4);

    // R3 divide by 8, R5 mid read, R10 writes ignored while busy
    host_write(2'd2, 32'd0);
    host_read(2'd2, rd); check_word("R11 divsel readback", rd, 32'd0);
    f = {2'b01, 2'b01, 5'd17, 5'd2, 2'b10, 16'h1234};
    host_write(2'd0, f);
    host_read(2'd1, rd); check_word("R2 done cleared on start", rd, 32'h1);
    repeat (27) @(negedge clk);
    jj = m_j;
    rises = jj / m_div + (((jj % m_div) >= m_div / 2) ? 1 : 0);
    host_read(2'd0, rd); check_word("R5 mid-transfer read", rd, rotl(f, rises));
    host_write(2'd0, 32'hFFFF_FFFF);
    host_write(2'd2, 32'd3);
    wait_idle();
    host_read(2'd0, rd); check_word("R10 frame write ignored", rd, f);
    host_read(2'd2, rd); check_word("R10 divsel write ignored", rd, 32'd0);

    // R7 clause 22 read frame at divide by 16
    host_write(2'd2, 32'd1);
    phy_data = 16'h3C5A;
    f = {2'b01, 2'b10, 5'd1, 5'd4, 2'b11, 16'hFFFF};
    host_write(2'd0, f);
    wait_idle();
    host_read(2'd0, rd);
    check_word("R7 read frame data", rd, {f[31:18], 2'b10, phy_data});

    // R8 clause 45 read frame at divide by 32
    host_write(2'd2, 32'd2);
    phy_data = 16'h9E01;
    f = {2'b00, 2'b11, 5'd6, 5'd1, 2'b11, 16'h0000};
    host_write(2'd0, f);
    wait_idle();
    host_read(2'd0, rd);
    check_word("R8 clause 45 read", rd, {f[31:18], 2'b10, phy_data});
    host_read(2'd1, rd); check_word("R9 done after read", rd, 32'h4);

    // R8 clause 45 write frame at divide by 8
    host_write(2'd2, 32'd0);
    f = {2'b00, 2'b01, 5'd30, 5'd31, 2'b10, 16'hC0DE};
    host_write(2'd0, f);
    wait_idle();
    host_read(2'd0, rd); check_word("R8 clause 45 write readback", rd, f);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule